// File: doc/BRIEF.md
# LIN Frame Checksum Engine

This block keeps the running checksum of a LIN frame while its bytes pass through a serial link controller, in either direction. The serialiser presents each byte on a one-cycle strobe and marks the protected identifier (the first byte after sync) with a separate flag. The block chooses by itself whether that identifier takes part in the sum, so that software never has to switch the rule frame by frame. A single control input can still pin every frame to the older rule that sums data bytes only.

While receiving, the checksum byte at the end of the frame is added like any other byte. A frame that arrived intact therefore leaves the inverted result at zero, and the block raises an OK flag. While transmitting, the block accepts at most a parameterised number of data bytes. On a send request it presents the checksum byte that the serialiser appends to the frame. A break pulse from the line receiver empties the accumulator.

Top module: `lin_cksum_engine`

## Requirements
- R1: After reset, and in the cycle after a pulse on `brk_det_i`, `cks_out_o` is 0xFF, `cks_ok_o` is 0 and the data-byte count is zero. A break takes priority over a byte arriving in the same cycle.
- R2: Each accepted data byte is added to the 8-bit sum. Any carry out of bit 7 is added back into bit 0 (0x80 + 0x80 gives 0x01). `cks_out_o` is the bitwise inverse of the sum and changes in the cycle after the byte strobe.
- R3: A byte strobed with `pid_mark_i` starts a new sum. If its identifier (bits 5:0) lies in 0x00..0x3B and `force_classic_i` is 0, the enhanced rule applies and the sum restarts at the PID value.
- R4: If the identifier is 0x3C or 0x3D (diagnostic) or 0x3E or 0x3F (reserved), the classic rule applies: the sum restarts at 0 and the PID is left out.
- R5: While `force_classic_i` is 1, every PID is left out of the sum, whatever its identifier.
- R6: A PID that arrives in the middle of a frame throws away the earlier sum and clears the data-byte count.
- R7: With `tx_mode_i` at 0 (receive), the received checksum byte is added like data. After the last data byte, `cks_out_o` equals the checksum the frame should carry. When at least two non-PID bytes have been summed and `cks_out_o` is 0x00, `cks_ok_o` is 1. A wrong checksum byte leaves `cks_ok_o` at 0.
- R8: With `tx_mode_i` at 1, data bytes beyond the eighth (parameter `MAX_DATA`) since the PID have no effect on the sum.
- R9: A pulse on `send_cks_i` with `tx_mode_i` at 1 gives a one-cycle `tx_cks_vld_o` in the next cycle. `tx_cks_byte_o` then equals the `cks_out_o` of the request cycle. In receive mode the request is ignored and `tx_cks_vld_o` stays 0.
- R10: `cks_ok_o` stays 0 in transmit mode, even when the sum has reached 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_det_i | input | 1 | Break detected; clears the sum and count |
| byte_vld_i | input | 1 | Strobe: `byte_i` holds a byte this cycle |
| byte_i | input | 8 | Byte received or transmitted |
| pid_mark_i | input | 1 | The strobed byte is the protected identifier |
| force_classic_i | input | 1 | Leave every PID out of the sum |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| send_cks_i | input | 1 | Request to append the checksum (transmit) |
| cks_out_o | output | 8 | Inverted running sum |
| cks_ok_o | output | 1 | Receive-mode checksum correct |
| tx_cks_vld_o | output | 1 | Checksum byte to append is valid |
| tx_cks_byte_o | output | 8 | Checksum byte to append |

## Verification
The bench chooses data whose sums carry out of bit 7. A plain modulo-256 adder would then produce checksums that are off by the number of carries. It sends PIDs on both sides of the 0x3B/0x3C border and with the force bit set. A wrong rule choice shows up at once as a `cks_out_o` that is off by exactly the PID value. It sends a tenth transmit byte, a mid-frame PID, a break and a send request in receive mode. A block that ignores the cap, keeps a stale sum or emits a checksum while receiving would then put out an unexpected byte, or one that does not match the scoreboard queue.

// File: rtl/lin_cksum_pkg.sv
package lin_cksum_pkg;

   typedef enum logic {
      RULE_ENHANCED = 1'b0,
      RULE_CLASSIC  = 1'b1
   } cks_rule_e;

   typedef enum logic [1:0] {
      ACC_HOLD  = 2'd0,
      ACC_CLEAR = 2'd1,
      ACC_LOAD  = 2'd2,
      ACC_ADD   = 2'd3
   } acc_op_e;

endpackage

// File: rtl/lin_cksum_rule.sv
module lin_cksum_rule
   import lin_cksum_pkg::*;
#(
   parameter int ID_W           = 6,
   parameter int CLASSIC_ID_MIN = 60
) (
   input  logic [ID_W-1:0] id_i,
   input  logic            force_classic_i,
   output cks_rule_e       rule_o
);

   localparam logic [ID_W-1:0] FIRST_CLASSIC = ID_W'(CLASSIC_ID_MIN);

   if (CLASSIC_ID_MIN >= (1 << ID_W)) begin : g_bad_min
      $error("CLASSIC_ID_MIN outside identifier range");
   end

   always_comb begin
      if (force_classic_i || (id_i >= FIRST_CLASSIC))
         rule_o = RULE_CLASSIC;
      else
         rule_o = RULE_ENHANCED;
   end

endmodule

// File: rtl/lin_cksum_ctrl.sv
module lin_cksum_ctrl
   import lin_cksum_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MAX_DATA = 8,
   localparam int CNT_W   = $clog2(MAX_DATA + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brk_i,
   input  logic              vld_i,
   input  logic              pid_i,
   input  logic              tx_i,
   input  cks_rule_e         rule_i,
   input  logic [DATA_W-1:0] byte_i,
   output acc_op_e           op_o,
   output logic [DATA_W-1:0] opnd_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam logic [CNT_W-1:0] TX_CAP  = CNT_W'(MAX_DATA);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_DATA + 1);

   if (MAX_DATA < 1) begin : g_bad_max
      $error("MAX_DATA must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             capped;

   assign capped = tx_i && (cnt_q >= TX_CAP);

   always_comb begin
      op_o   = ACC_HOLD;
      opnd_o = byte_i;
      if (brk_i) begin
         op_o = ACC_CLEAR;
      end else if (vld_i && pid_i) begin
         op_o   = ACC_LOAD;
         opnd_o = (rule_i == RULE_CLASSIC) ? '0 : byte_i;
      end else if (vld_i && !capped) begin
         op_o = ACC_ADD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (op_o == ACC_CLEAR || op_o == ACC_LOAD)
         cnt_q <= '0;
      else if (op_o == ACC_ADD && cnt_q != CNT_TOP)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R6
   pid_cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && pid_i) |=> (cnt_q == '0));

endmodule

// File: rtl/lin_cksum_acc.sv
module lin_cksum_acc
   import lin_cksum_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit END_AROUND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_op_e           op_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] acc_o
);

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] sum;

   if (END_AROUND) begin : g_fold
      logic [DATA_W:0] raw;
      assign raw = {1'b0, acc_q} + {1'b0, data_i};
      assign sum = raw[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, raw[DATA_W]};
   end else begin : g_wrap
      assign sum = acc_q + data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         case (op_i)
            ACC_CLEAR: acc_q <= '0;
            ACC_LOAD:  acc_q <= data_i;
            ACC_ADD:   acc_q <= sum;
            default:   acc_q <= acc_q;
         endcase
      end
   end

   assign acc_o = acc_q;

   // R1
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == ACC_CLEAR) |=> (acc_q == '0));

   // R3
   acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == ACC_LOAD) |=> (acc_q == $past(data_i)));

endmodule

// File: rtl/lin_cksum_engine.sv
module lin_cksum_engine
   import lin_cksum_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ID_W           = 6,
   parameter int MAX_DATA       = 8,
   parameter int CLASSIC_ID_MIN = 60,
   parameter bit END_AROUND     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        brk_det_i,
   input  logic        byte_vld_i,
   input  logic [7:0]  byte_i,
   input  logic        pid_mark_i,
   input  logic        force_classic_i,
   input  logic        tx_mode_i,
   input  logic        send_cks_i,
   output logic [7:0]  cks_out_o,
   output logic        cks_ok_o,
   output logic        tx_cks_vld_o,
   output logic [7:0]  tx_cks_byte_o
);

   localparam int CNT_W = $clog2(MAX_DATA + 2);
   localparam logic [CNT_W-1:0] OK_MIN = CNT_W'(2);
   localparam logic [CNT_W-1:0] TX_CAP = CNT_W'(MAX_DATA);

   if (DATA_W != 8) begin : g_bad_bus
      $error("LIN bytes are 8 bits wide");
   end
   if (ID_W >= DATA_W) begin : g_bad_id
      $error("ID_W must be narrower than DATA_W");
   end

   cks_rule_e         rule;
   acc_op_e           op;
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] acc;
   logic [CNT_W-1:0]  cnt;

   lin_cksum_rule #(.ID_W(ID_W), .CLASSIC_ID_MIN(CLASSIC_ID_MIN)) u_rule (
      .id_i            (byte_i[ID_W-1:0]),
      .force_classic_i (force_classic_i),
      .rule_o          (rule)
   );

   lin_cksum_ctrl #(.DATA_W(DATA_W), .MAX_DATA(MAX_DATA)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .brk_i  (brk_det_i),
      .vld_i  (byte_vld_i),
      .pid_i  (pid_mark_i),
      .tx_i   (tx_mode_i),
      .rule_i (rule),
      .byte_i (byte_i),
      .op_o   (op),
      .opnd_o (opnd),
      .cnt_o  (cnt)
   );

   lin_cksum_acc #(.DATA_W(DATA_W), .END_AROUND(END_AROUND)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op),
      .data_i (opnd),
      .acc_o  (acc)
   );

   assign cks_out_o = ~acc;
   assign cks_ok_o  = !tx_mode_i && (cnt >= OK_MIN) && (acc == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_cks_vld_o  <= 1'b0;
         tx_cks_byte_o <= '0;
      end else begin
         tx_cks_vld_o <= send_cks_i && tx_mode_i;
         if (send_cks_i && tx_mode_i)
            tx_cks_byte_o <= ~acc;
      end
   end

   // R1
   brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_det_i |=> (cks_out_o == 8'hFF && !cks_ok_o));

   // R5
   force_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && pid_mark_i && force_classic_i && !brk_det_i)
      |=> (cks_out_o == 8'hFF));

   // R8
   tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode_i && byte_vld_i && !pid_mark_i && !brk_det_i && cnt >= TX_CAP)
      |=> $stable(cks_out_o));

   // R9
   tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send_cks_i && tx_mode_i) |=> (tx_cks_vld_o && tx_cks_byte_o == $past(cks_out_o)));

   // R9
   rx_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(send_cks_i && tx_mode_i) |=> !tx_cks_vld_o);

endmodule

// File: tb/tb_lin_cksum_engine.sv
module tb_lin_cksum_engine;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       brk = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] bdat = 8'h00;
   logic       pid = 1'b0;
   logic       fcl = 1'b0;
   logic       txm = 1'b0;
   logic       send = 1'b0;
   logic [7:0] cks_out;
   logic       cks_ok;
   logic       tx_vld;
   logic [7:0] tx_byte;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_acc = 8'h00;
   int         m_cnt = 0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_cksum_engine dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .brk_det_i       (brk),
      .byte_vld_i      (vld),
      .byte_i          (bdat),
      .pid_mark_i      (pid),
      .force_classic_i (fcl),
      .tx_mode_i       (txm),
      .send_cks_i      (send),
      .cks_out_o       (cks_out),
      .cks_ok_o        (cks_ok),
      .tx_cks_vld_o    (tx_vld),
      .tx_cks_byte_o   (tx_byte)
   );

   function automatic logic [7:0] fold(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[7:0] + {7'd0, s[8]};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input bit is_pid, input string req);
      @(negedge clk);
      vld = 1'b1; bdat = b; pid = is_pid;
      @(negedge clk);
      vld = 1'b0; pid = 1'b0;
      if (is_pid) begin
         m_acc = (fcl || b[5:0] >= 6'h3C) ? 8'h00 : b;
         m_cnt = 0;
      end else if (!(txm && m_cnt >= 8)) begin
         m_acc = fold(m_acc, b);
         if (m_cnt < 9) m_cnt++;
      end
      chk(req, {24'd0, cks_out}, {24'd0, ~m_acc});
   endtask

   task automatic do_brk();
      @(negedge clk);
      brk = 1'b1; vld = 1'b1; bdat = 8'h55;
      @(negedge clk);
      brk = 1'b0; vld = 1'b0;
      m_acc = 8'h00; m_cnt = 0;
      chk("R1 break cks", {24'd0, cks_out}, 32'hFF);
      chk("R1 break ok", {31'd0, cks_ok}, 32'd0);
   endtask

   task automatic req_cks();
      @(negedge clk);
      send = 1'b1;
      if (txm) exp_q.push_back(~m_acc);
      @(negedge clk);
      send = 1'b0;
      @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && tx_vld) begin
         if (exp_q.size() == 0) begin
            chk("R9 unexpected tx checksum", {31'd0, tx_vld}, 32'd0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R9 tx checksum byte", {24'd0, tx_byte}, {24'd0, e});
         end
      end
   end

   task automatic rx_frame(input logic [7:0] p, input int n, input logic [7:0] seed,
                           input bit good, input string req);
      logic [7:0] c;
      put(p, 1'b1, req);
      for (int i = 0; i < n; i++) put(seed + 8'(i * 37), 1'b0, req);
      c = good ? ~m_acc : (~m_acc ^ 8'h01);
      put(c, 1'b0, "R7 checksum byte folded");
      chk(good ? "R7 ok on good frame" : "R7 ok on bad frame",
          {31'd0, cks_ok}, {31'd0, good});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset cks", {24'd0, cks_out}, 32'hFF);
      chk("R1 reset ok", {31'd0, cks_ok}, 32'd0);
      chk("R1 reset tx vld", {31'd0, tx_vld}, 32'd0);

      // R2 end-around carry: 0x80+0x80 -> 0x01
      put(8'h3C, 1'b1, "R4 diag pid");
      put(8'h80, 1'b0, "R2 add");
      put(8'h80, 1'b0, "R2 carry fold");
      chk("R2 carry value", {24'd0, cks_out}, 32'hFE);

      // R3 enhanced frames, identifier at border 0x3B
      rx_frame(8'h50, 4, 8'hF1, 1'b1, "R3 enhanced");
      rx_frame(8'hFB, 8, 8'hC7, 1'b1, "R3 enhanced id 3B");
      // R4 classic identifiers
      rx_frame(8'h3C, 8, 8'hFF, 1'b1, "R4 classic 3C");
      rx_frame(8'h7D, 3, 8'h90, 1'b1, "R4 classic 3D");
      rx_frame(8'hBE, 2, 8'h81, 1'b1, "R4 classic 3E");
      rx_frame(8'hFF, 5, 8'hA5, 1'b1, "R4 classic 3F");
      // R7 wrong checksum
      rx_frame(8'h12, 4, 8'h66, 1'b0, "R7 bad frame");

      // R5 force classic
      fcl = 1'b1;
      put(8'h50, 1'b1, "R5 forced pid skipped");
      chk("R5 forced start", {24'd0, cks_out}, 32'hFF);
      put(8'h21, 1'b0, "R5 forced data");
      fcl = 1'b0;

      // R6 mid-frame pid restarts
      put(8'h05, 1'b1, "R6 first pid");
      put(8'hEE, 1'b0, "R6 data");
      put(8'h33, 1'b0, "R6 data");
      put(8'h11, 1'b1, "R6 restart pid");
      chk("R6 restarted sum", {24'd0, cks_out}, {24'd0, ~8'h11});

      // R1 break mid-frame, with a byte in the same cycle
      put(8'h44, 1'b0, "R2 data before break");
      do_brk();

      // R9 request ignored in receive mode
      rx_frame(8'h22, 2, 8'h10, 1'b1, "R7 before rx request");
      req_cks();
      chk("R9 rx request ignored", {31'd0, tx_vld}, 32'd0);

      // R8 transmit cap and R9 emission
      txm = 1'b1;
      put(8'h20, 1'b1, "R3 tx pid");
      for (int i = 0; i < 8; i++) put(8'(8'hD0 + i), 1'b0, "R2 tx data");
      put(8'h77, 1'b0, "R8 ninth byte ignored");
      put(8'h01, 1'b0, "R8 tenth byte ignored");
      req_cks();

      // R10 ok stays low in transmit with sum 0xFF
      put(8'h3D, 1'b1, "R4 tx classic pid");
      put(8'h5A, 1'b0, "R2 tx data");
      put(8'hA5, 1'b0, "R10 sum reaches FF");
      chk("R10 ok low in tx", {31'd0, cks_ok}, 32'd0);
      chk("R10 sum FF", {24'd0, cks_out}, 32'h00);
      req_cks();

      repeat (3) @(negedge clk);
      chk("R9 all tx checksums seen", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule